// File: doc/BRIEF.md
# Bus Request and Read-Latency Stage

This block sits between a processor-facing bus interface and a set of internal user cores. It turns each accepted host write or read into a single-cycle request toward the cores. The address, the request strobe and, for writes, the write data all appear on the core side in the same clock cycle. On a write it returns a one-cycle completion pulse on the following cycle.

On a read, the block delays the request through a short shift register before it samples the core-side read data. The cores and their read multiplexer therefore have a fixed number of cycles to present their value. The depth of that delay is the parameter `READ_LAT`. A value of 1 suits cores with registered outputs behind a combinational multiplexer. A value of 2 suits a multiplexer with its own pipeline register. The sampled word is latched, returned on the host side and marked by a one-cycle done pulse.

While a read is in flight, the block raises a busy output and drops any host request that arrives. When a write and a read arrive together, the write is taken and the read is dropped. `READ_LAT` outside 1..2 is rejected at elaboration.

Top module: `bus_req_stage`

## Requirements
- R1: A `host_wr` accepted while `busy` is low gives `core_we` high for exactly the next cycle. In that same cycle `core_addr` equals the host address and `core_wdata` equals the host write data.
- R2: A `host_rd` accepted while `busy` is low gives `core_re` high for exactly the next cycle, with `core_addr` equal to the host address and `core_we` low.
- R3: In every cycle where `core_we` is low, `core_wdata` is all zeros.
- R4: `core_rdata` is sampled at the end of the cycle that lies `READ_LAT` cycles after the `core_re` cycle. In the following cycle `host_rdata` shows the sampled word and `rd_done` is high for that one cycle. `host_rdata` then holds that word until the next capture.
- R5: `wr_done` is high for exactly the cycle after each `core_we` cycle and at no other time.
- R6: `busy` is high from the `core_re` cycle through the sampling cycle, and low in the `rd_done` cycle. Any host request presented while `busy` is high produces no core strobe and no done pulse.
- R7: If `host_wr` and `host_rd` are both high in an accepting cycle, only the write is issued. No `core_re`, no `rd_done` and no change of `host_rdata` follows.
- R8: Synchronous reset clears the delay pipeline, `host_rdata`, `core_we`, `core_re`, `wr_done`, `rd_done` and `busy`. A read in flight when reset is applied produces no `rd_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_wr | input | 1 | Host write request, one cycle |
| host_rd | input | 1 | Host read request, one cycle |
| host_addr | input | AW | Host address |
| host_wdata | input | DW | Host write data |
| busy | output | 1 | Read in flight; requests are dropped |
| host_rdata | output | DW | Latched read data |
| rd_done | output | 1 | One-cycle pulse: `host_rdata` is new |
| wr_done | output | 1 | One-cycle pulse: write issued |
| core_addr | output | AW | Address to the cores |
| core_wdata | output | DW | Write data to the cores, zero unless writing |
| core_we | output | 1 | One-cycle write strobe to the cores |
| core_re | output | 1 | One-cycle read strobe to the cores |
| core_rdata | input | DW | Read data from the core multiplexer |

## Verification
The checker covers the relations that hold on every cycle. Each core strobe must trace back to a host request that arrived while idle. Read and write strobes never overlap. Write data is zero outside writes. Done pulses follow their strobes at the fixed distance, and busy covers the read window. What only the bench scenarios can show is data correctness: the returned word must be the one the core placed for that address, it must stay latched between reads, and the dropped requests (while busy or on a collision) must leave no trace on the core side. Two further cases also need the bench: a reset cutting off a read in flight, and a new read accepted in the very cycle of the previous `rd_done`.

// File: rtl/bus_stage_pkg.sv
package bus_stage_pkg;

   localparam int unsigned LAT_MIN = 1;
   localparam int unsigned LAT_MAX = 2;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_WRITE = 2'd1,
      OP_READ  = 2'd2
   } bus_op_e;

endpackage

// File: rtl/bsr_issue.sv
module bsr_issue
   import bus_stage_pkg::*;
#(
   parameter int unsigned AW = 16,
   parameter int unsigned DW = 32
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          host_wr,
   input  logic          host_rd,
   input  logic [AW-1:0] host_addr,
   input  logic [DW-1:0] host_wdata,
   input  logic          hold_off,
   output logic          core_we,
   output logic          core_re,
   output logic [AW-1:0] core_addr,
   output logic [DW-1:0] core_wdata,
   output logic          wr_done
);

   bus_op_e op_sel;

   // write has priority; everything is dropped while a read is in flight
   always_comb begin
      op_sel = OP_IDLE;
      if (!hold_off) begin
         if (host_wr)      op_sel = OP_WRITE;
         else if (host_rd) op_sel = OP_READ;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         core_we    <= 1'b0;
         core_re    <= 1'b0;
         core_addr  <= '0;
         core_wdata <= '0;
         wr_done    <= 1'b0;
      end else begin
         core_we    <= (op_sel == OP_WRITE);
         core_re    <= (op_sel == OP_READ);
         core_wdata <= (op_sel == OP_WRITE) ? host_wdata : '0;
         wr_done    <= core_we;
         if (op_sel != OP_IDLE) core_addr <= host_addr;
      end
   end

endmodule

// File: rtl/bsr_delay.sv
module bsr_delay #(
   parameter int unsigned DEPTH = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic pulse_in,
   output logic tap_out,
   output logic pending
);

   if (DEPTH == 1) begin : g_single
      logic stage_q;
      always_ff @(posedge clk) begin
         if (rst) stage_q <= 1'b0;
         else     stage_q <= pulse_in;
      end
      assign tap_out = stage_q;
      assign pending = stage_q;
   end else begin : g_chain
      logic [DEPTH-1:0] chain_q;
      always_ff @(posedge clk) begin
         if (rst) chain_q <= '0;
         else     chain_q <= {chain_q[DEPTH-2:0], pulse_in};
      end
      assign tap_out = chain_q[DEPTH-1];
      assign pending = |chain_q;
   end

endmodule

// File: rtl/bsr_capture.sv
module bsr_capture #(
   parameter int unsigned DW = 32
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          sample,
   input  logic [DW-1:0] core_rdata,
   output logic [DW-1:0] host_rdata,
   output logic          rd_done
);

   always_ff @(posedge clk) begin
      if (rst) begin
         host_rdata <= '0;
         rd_done    <= 1'b0;
      end else begin
         rd_done <= sample;
         if (sample) host_rdata <= core_rdata;
      end
   end

endmodule

// File: rtl/bus_req_stage.sv
module bus_req_stage
   import bus_stage_pkg::*;
#(
   parameter int unsigned AW       = 16,
   parameter int unsigned DW       = 32,
   parameter int unsigned READ_LAT = 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          host_wr,
   input  logic          host_rd,
   input  logic [AW-1:0] host_addr,
   input  logic [DW-1:0] host_wdata,
   output logic          busy,
   output logic [DW-1:0] host_rdata,
   output logic          rd_done,
   output logic          wr_done,
   output logic [AW-1:0] core_addr,
   output logic [DW-1:0] core_wdata,
   output logic          core_we,
   output logic          core_re,
   input  logic [DW-1:0] core_rdata
);

   if (READ_LAT < LAT_MIN || READ_LAT > LAT_MAX) begin : g_bad_lat
      $error("bus_req_stage: READ_LAT must be 1 or 2");
   end
   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("bus_req_stage: AW and DW must be positive");
   end

   logic sample_now;
   logic dly_pending;

   bsr_issue #(.AW(AW), .DW(DW)) i_issue (
      .clk        (clk),
      .rst        (rst),
      .host_wr    (host_wr),
      .host_rd    (host_rd),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .hold_off   (busy),
      .core_we    (core_we),
      .core_re    (core_re),
      .core_addr  (core_addr),
      .core_wdata (core_wdata),
      .wr_done    (wr_done)
   );

   bsr_delay #(.DEPTH(READ_LAT)) i_delay (
      .clk      (clk),
      .rst      (rst),
      .pulse_in (core_re),
      .tap_out  (sample_now),
      .pending  (dly_pending)
   );

   bsr_capture #(.DW(DW)) i_capture (
      .clk        (clk),
      .rst        (rst),
      .sample     (sample_now),
      .core_rdata (core_rdata),
      .host_rdata (host_rdata),
      .rd_done    (rd_done)
   );

   assign busy = core_re | dly_pending;

endmodule

// File: rtl/bus_req_stage_chk.sv
module bus_req_stage_chk #(
   parameter int unsigned AW       = 16,
   parameter int unsigned DW       = 32,
   parameter int unsigned READ_LAT = 1
) (
   input logic          clk,
   input logic          rst,
   input logic          host_wr,
   input logic          host_rd,
   input logic [AW-1:0] host_addr,
   input logic [DW-1:0] host_wdata,
   input logic          busy,
   input logic [DW-1:0] host_rdata,
   input logic          rd_done,
   input logic          wr_done,
   input logic [AW-1:0] core_addr,
   input logic [DW-1:0] core_wdata,
   input logic          core_we,
   input logic          core_re,
   input logic [DW-1:0] core_rdata
);

   a_r1_we_from_request: assert property (@(posedge clk) disable iff (rst)
      core_we |-> ($past(host_wr) && !$past(busy)));

   a_r1_wdata_passed: assert property (@(posedge clk) disable iff (rst)
      core_we |-> (core_wdata == $past(host_wdata) && core_addr == $past(host_addr)));

   a_r2_re_from_request: assert property (@(posedge clk) disable iff (rst)
      core_re |-> ($past(host_rd) && !$past(host_wr) && !$past(busy)));

   a_r2_no_overlap: assert property (@(posedge clk) disable iff (rst)
      !(core_we && core_re));

   a_r3_wdata_quiet: assert property (@(posedge clk) disable iff (rst)
      !core_we |-> (core_wdata == '0));

   a_r4_done_spacing: assert property (@(posedge clk) disable iff (rst)
      rd_done |-> $past(core_re, READ_LAT + 1));

   a_r4_data_held: assert property (@(posedge clk) disable iff (rst)
      (!rd_done && !$past(rst)) |-> $stable(host_rdata));

   a_r5_wr_done_follows: assert property (@(posedge clk) disable iff (rst)
      core_we |=> wr_done);

   a_r5_wr_done_cause: assert property (@(posedge clk) disable iff (rst)
      wr_done |-> $past(core_we));

   a_r6_busy_window: assert property (@(posedge clk) disable iff (rst)
      core_re |-> busy);

   a_r6_idle_at_done: assert property (@(posedge clk) disable iff (rst)
      rd_done |-> !busy);

   a_r8_reset_clears: assert property (@(posedge clk)
      rst |=> (!core_we && !core_re && !busy && !rd_done && !wr_done && host_rdata == '0));

endmodule

bind bus_req_stage bus_req_stage_chk #(.AW(AW), .DW(DW), .READ_LAT(READ_LAT)) i_chk (.*);

// File: tb/test_bus_req_stage.sv
module test_bus_req_stage;

   localparam int unsigned AW = 16;
   localparam int unsigned DW = 32;
   localparam int NV = 8;

   typedef struct packed {
      logic          is_wr;
      logic [AW-1:0] addr;
      logic [DW-1:0] data;
   } vec_t;

   localparam vec_t VECS [NV] = '{
      '{1'b1, 16'h0010, 32'hDEAD_BEEF},
      '{1'b0, 16'h0010, 32'h0},
      '{1'b1, 16'hFFFF, 32'hFFFF_FFFF},
      '{1'b0, 16'h0000, 32'h0},
      '{1'b0, 16'hFFFF, 32'h0},
      '{1'b1, 16'h0000, 32'h0000_0001},
      '{1'b0, 16'h1234, 32'h0},
      '{1'b1, 16'h8001, 32'h8000_0000}
   };

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          host_wr = 1'b0;
   logic          host_rd = 1'b0;
   logic [AW-1:0] host_addr = '0;
   logic [DW-1:0] host_wdata = '0;
   logic          busy;
   logic [DW-1:0] host_rdata;
   logic          rd_done;
   logic          wr_done;
   logic [AW-1:0] core_addr;
   logic [DW-1:0] core_wdata;
   logic          core_we;
   logic          core_re;
   logic [DW-1:0] core_rdata;

   int n_cmp = 0;
   int n_bad = 0;
   logic [DW-1:0] last_rd = '0;

   always #10 clk = ~clk;   // 50 MHz

   bus_req_stage #(.AW(AW), .DW(DW), .READ_LAT(1)) i_bus_req_stage (
      .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
      .host_addr(host_addr), .host_wdata(host_wdata), .busy(busy),
      .host_rdata(host_rdata), .rd_done(rd_done), .wr_done(wr_done),
      .core_addr(core_addr), .core_wdata(core_wdata), .core_we(core_we),
      .core_re(core_re), .core_rdata(core_rdata)
   );

   // model core: registered output, value derived from address
   function automatic logic [DW-1:0] core_val(input logic [AW-1:0] a);
      return {a, ~a} ^ 32'h5A5A_0F0F;
   endfunction

   always_ff @(posedge clk) begin
      if (rst)          core_rdata <= '0;
      else if (core_re) core_rdata <= core_val(core_addr);
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // read with LAT=1: strobe at N1, busy N1..N2, done at N3
   task automatic do_read(input logic [AW-1:0] a);
      host_rd = 1'b1; host_addr = a;
      @(negedge clk);
      host_rd = 1'b0;
      chk("R2 core_re", core_re, 1);
      chk("R2 core_addr", core_addr, a);
      chk("R2 core_we low", core_we, 0);
      chk("R6 busy at strobe", busy, 1);
      @(negedge clk);
      chk("R2 core_re single", core_re, 0);
      chk("R6 busy in window", busy, 1);
      chk("R4 no early done", rd_done, 0);
      @(negedge clk);
      chk("R4 rd_done", rd_done, 1);
      chk("R4 host_rdata", host_rdata, core_val(a));
      chk("R6 busy low at done", busy, 0);
      last_rd = core_val(a);
      @(negedge clk);
      chk("R4 rd_done single", rd_done, 0);
      chk("R4 data held", host_rdata, last_rd);
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0; host_wdata = '0;
      chk("R1 core_we", core_we, 1);
      chk("R1 core_addr", core_addr, a);
      chk("R1 core_wdata", core_wdata, d);
      chk("R5 no early wr_done", wr_done, 0);
      @(negedge clk);
      chk("R1 core_we single", core_we, 0);
      chk("R3 wdata zero", core_wdata, 0);
      chk("R5 wr_done", wr_done, 1);
      @(negedge clk);
      chk("R5 wr_done single", wr_done, 0);
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R8 reset busy", busy, 0);
      chk("R8 reset rdata", host_rdata, 0);
      chk("R8 reset strobes", {core_we, core_re, rd_done, wr_done}, 0);
      chk("R3 wdata zero in reset", core_wdata, 0);
      rst = 1'b0;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         if (VECS[i].is_wr) do_write(VECS[i].addr, VECS[i].data);
         else               do_read(VECS[i].addr);
      end

      // R6: requests during busy are dropped
      host_rd = 1'b1; host_addr = 16'h0A0A;
      @(negedge clk);
      host_rd = 1'b0;
      host_wr = 1'b1; host_addr = 16'h0B0B; host_wdata = 32'h1111_2222;
      @(negedge clk);
      host_wr = 1'b0; host_rd = 1'b1; host_addr = 16'h0C0C;
      chk("R6 dropped write no core_we", core_we, 0);
      chk("R6 addr kept", core_addr, 16'h0A0A);
      chk("R3 wdata zero", core_wdata, 0);
      @(negedge clk);
      host_rd = 1'b0;
      chk("R4 rd_done busy case", rd_done, 1);
      chk("R4 data busy case", host_rdata, core_val(16'h0A0A));
      chk("R6 dropped read no core_re", core_re, 0);
      chk("R6 dropped write no wr_done", wr_done, 0);
      last_rd = core_val(16'h0A0A);
      @(negedge clk);
      chk("R6 no extra done", {rd_done, wr_done, core_re, core_we}, 0);
      chk("R6 data held", host_rdata, last_rd);

      // R7: collision, write wins
      host_wr = 1'b1; host_rd = 1'b1; host_addr = 16'h7777; host_wdata = 32'hCAFE_0007;
      @(negedge clk);
      host_wr = 1'b0; host_rd = 1'b0; host_wdata = '0;
      chk("R7 write issued", core_we, 1);
      chk("R7 read dropped", core_re, 0);
      chk("R7 not busy", busy, 0);
      @(negedge clk);
      chk("R7 wr_done", wr_done, 1);
      @(negedge clk);
      chk("R7 no rd_done", rd_done, 0);
      chk("R7 rdata unchanged", host_rdata, last_rd);

      // back-to-back: new read accepted in rd_done cycle
      host_rd = 1'b1; host_addr = 16'h00A1;
      @(negedge clk);
      host_rd = 1'b0;
      @(negedge clk);
      host_rd = 1'b1; host_addr = 16'h00B2;
      chk("R6 second read held off", core_re, 0);
      @(negedge clk);
      chk("R4 first done", rd_done, 1);
      chk("R4 first data", host_rdata, core_val(16'h00A1));
      chk("R6 accept at done", busy, 0);
      @(negedge clk);
      host_rd = 1'b0;
      chk("R2 second strobe", core_re, 1);
      chk("R2 second addr", core_addr, 16'h00B2);
      @(negedge clk);
      @(negedge clk);
      chk("R4 second done", rd_done, 1);
      chk("R4 second data", host_rdata, core_val(16'h00B2));

      // R8: reset during a read in flight
      @(negedge clk);
      host_rd = 1'b1; host_addr = 16'h3C3C;
      @(negedge clk);
      host_rd = 1'b0; rst = 1'b1;
      chk("R2 strobe before reset", core_re, 1);
      @(negedge clk);
      rst = 1'b0;
      chk("R8 busy cleared", busy, 0);
      chk("R8 rdata cleared", host_rdata, 0);
      chk("R8 strobes cleared", {core_re, rd_done}, 0);
      @(negedge clk);
      chk("R8 no late done", rd_done, 0);
      @(negedge clk);
      chk("R8 still no done", rd_done, 0);

      summary();
   end

endmodule